// File: doc/BRIEF.md
# Nonvolatile Configuration Refresh Controller

This block fronts a six-byte nonvolatile configuration area that is reached through a byte-wide register port. Each nonvolatile byte has a live shadow register. While automatic refresh is switched on, all six shadows are reloaded from the nonvolatile cells at a fixed interval. Host reads of a nonvolatile address always return the shadow. The decoded fields of the main configuration byte drive neighbouring logic directly.

To change a nonvolatile byte, software first clears the refresh-enable bit in the control register. It then writes the address, which starts a programming cycle of fixed length, and polls the busy bit in the status register until the cycle ends. Finally it sets refresh-enable again so the new value reaches the shadow.

An external supply monitor raises two low-voltage inputs. Each one sets a sticky status flag. Programming is refused while either flag or either input is high.

Top module: `nvcfg_refresh_ctrl`

## Requirements
- R1: After reset the control register (address 0x00) reads 0x08, with refresh enabled in bit 3. The status register (address 0x03) reads 0x00. Every nonvolatile address reads 0x00 and every configuration output is 0 until the first refresh.
- R2: While control bit 3 is 1 and no programming cycle runs, all six shadows load from the nonvolatile cells once every REFRESH_PERIOD cycles. The interval counter restarts from zero whenever refresh is off or a cycle is busy.
- R3: A read of a nonvolatile address (0x28, 0x29, 0x30 to 0x33) returns the shadow value. This holds during a programming cycle and also after a commit, until a later refresh.
- R4: A write to a nonvolatile address is accepted when control bit 3 is 0, no cycle is busy and no low-voltage condition exists. Status bit 7 (and busy_o) is then high for exactly PROG_CYCLES cycles, starting in the cycle after the write, and the byte is committed to the nonvolatile cell when it falls.
- R5: A nonvolatile write while control bit 3 is 1 is ignored: busy stays 0 and the cell keeps its old value.
- R6: Status bit 2 is set and held while supply_low1_in is high, and status bit 3 does the same for supply_low2_in. Writing 0 to a flag bit at address 0x03 clears it and writing 1 leaves it unchanged. A monitor input that is high in the same cycle as a clearing write wins, so the flag stays set.
- R7: A nonvolatile write is refused, with no busy and no change to the cell, while either status flag is set or either monitor input is high in that cycle.
- R8: A nonvolatile write that arrives while a programming cycle is busy is dropped.
- R9: No refresh happens while busy, even if refresh has been switched back on during the cycle.
- R10: The outputs decode the shadow of byte 0x30: bit 0 gives cfg_scan_slow_o, bit 1 gives cfg_therm_en_o, bits 3:2 give cfg_clkdiv_o and bits 7:4 give cfg_charge_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address for read and write |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| supply_low1_in | input | 1 | First low-voltage indication from supply monitor |
| supply_low2_in | input | 1 | Second low-voltage indication from supply monitor |
| busy_o | output | 1 | Programming cycle in progress |
| cfg_scan_slow_o | output | 1 | Temperature scan period select |
| cfg_therm_en_o | output | 1 | Thermometer enable |
| cfg_clkdiv_o | output | 2 | Clock-out divider select |
| cfg_charge_sel_o | output | 4 | Charger resistor select |

## Verification
Two functions can land in the same cycle. In the first, the supply monitor raises an input in the cycle where software writes 0 to clear that same flag. The bench drives both on one clock edge, and a later status read must still show the flag set. In the second, a monitor input rises in the very cycle of a nonvolatile write. The bench drives both together and judges the outcome by busy_o staying low and by the cell keeping its old value, which is seen through the shadow after refresh is re-enabled.

// File: rtl/nvcfg_refresh_ctrl.sv
module nvcfg_refresh_ctrl #(
  parameter int          PROG_CYCLES    = 40,
  parameter int          REFRESH_PERIOD = 16,
  parameter logic [47:0] NV_INIT        = 48'h33_22_11_A6_B2_A1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       supply_low1_in,
  input  logic       supply_low2_in,
  output logic       busy_o,
  output logic       cfg_scan_slow_o,
  output logic       cfg_therm_en_o,
  output logic [1:0] cfg_clkdiv_o,
  output logic [3:0] cfg_charge_sel_o
);

  localparam int NB = 6;
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam int RW = $clog2(REFRESH_PERIOD + 1);
  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_STAT = 8'h03;

  logic [7:0]      ctrl_q;
  logic            low1_q, low2_q, busy_q;
  logic [PW-1:0]   prog_cnt;
  logic [RW-1:0]   ref_cnt;
  logic [2:0]      pend_idx;
  logic [7:0]      pend_data;
  logic [NB*8-1:0] nv_q, shadow_q;
  logic            nv_hit;
  logic [2:0]      nv_idx;

  always_comb begin
    nv_hit = 1'b1;
    nv_idx = 3'd0;
    case (reg_addr)
      8'h28: nv_idx = 3'd0;
      8'h29: nv_idx = 3'd1;
      8'h30, 8'h31, 8'h32, 8'h33: nv_idx = 3'd2 + {1'b0, reg_addr[1:0]};
      default: nv_hit = 1'b0;
    endcase
  end

  wire rfen       = ctrl_q[3];
  wire low_any    = low1_q | low2_q | supply_low1_in | supply_low2_in;
  wire prog_start = reg_we && nv_hit && !rfen && !busy_q && !low_any;
  wire prog_done  = busy_q && (prog_cnt == '0);
  wire ref_tick   = rfen && !busy_q && (ref_cnt == RW'(REFRESH_PERIOD - 1));
  wire stat_we    = reg_we && (reg_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 8'h08;
      low1_q <= 1'b0;
      low2_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata;
      low1_q <= supply_low1_in | (low1_q & ~(stat_we & ~reg_wdata[2]));
      low2_q <= supply_low2_in | (low2_q & ~(stat_we & ~reg_wdata[3]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      prog_cnt  <= '0;
      pend_idx  <= 3'd0;
      pend_data <= 8'h00;
      nv_q      <= NV_INIT;
    end else if (prog_start) begin
      busy_q    <= 1'b1;
      prog_cnt  <= PW'(PROG_CYCLES - 1);
      pend_idx  <= nv_idx;
      pend_data <= reg_wdata;
    end else if (busy_q) begin
      if (prog_done) begin
        busy_q <= 1'b0;
        nv_q[pend_idx*8 +: 8] <= pend_data;
      end else begin
        prog_cnt <= prog_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      shadow_q <= '0;
    end else if (!rfen || busy_q) begin
      ref_cnt <= '0;
    end else if (ref_tick) begin
      ref_cnt  <= '0;
      shadow_q <= nv_q;
    end else begin
      ref_cnt <= ref_cnt + 1'b1;
    end
  end

  always_comb begin
    if (reg_addr == ADDR_CTRL)      reg_rdata = ctrl_q;
    else if (reg_addr == ADDR_STAT) reg_rdata = {busy_q, 3'b000, low2_q, low1_q, 2'b00};
    else if (nv_hit)                reg_rdata = shadow_q[nv_idx*8 +: 8];
    else                            reg_rdata = 8'h00;
  end

  assign busy_o           = busy_q;
  assign cfg_scan_slow_o  = shadow_q[16];
  assign cfg_therm_en_o   = shadow_q[17];
  assign cfg_clkdiv_o     = shadow_q[19:18];
  assign cfg_charge_sel_o = shadow_q[23:20];

endmodule

// File: rtl/nvcfg_refresh_ctrl_chk.sv
module nvcfg_refresh_ctrl_chk #(
  parameter int PROG_CYCLES = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rfen,
  input logic        low1,
  input logic        low2,
  input logic        low1_in,
  input logic        low2_in,
  input logic [47:0] shadow
);

  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= busy ? run + 16'd1 : 16'd0;
  end

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 16'(PROG_CYCLES));

  assert_busy_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == 16'(PROG_CYCLES));

  assert_no_start_rfen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!rfen));

  assert_no_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!low1 && !low2 && !low1_in && !low2_in));

  assert_flag1_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low1_in |=> low1);

  assert_flag2_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    low2_in |=> low2);

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(shadow));

endmodule

bind nvcfg_refresh_ctrl nvcfg_refresh_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_q),
  .rfen    (ctrl_q[3]),
  .low1    (low1_q),
  .low2    (low2_q),
  .low1_in (supply_low1_in),
  .low2_in (supply_low2_in),
  .shadow  (shadow_q)
);

// File: tb/nvcfg_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvcfg_refresh_ctrl_tb_top;
  localparam int PROG = 40;
  localparam int PER  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       low1 = 1'b0, low2 = 1'b0;
  logic       busy_o, scan_slow, therm_en;
  logic [1:0] clkdiv;
  logic [3:0] charge;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nvcfg_refresh_ctrl #(.PROG_CYCLES(PROG), .REFRESH_PERIOD(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .supply_low1_in(low1), .supply_low2_in(low2), .busy_o(busy_o),
    .cfg_scan_slow_o(scan_slow), .cfg_therm_en_o(therm_en),
    .cfg_clkdiv_o(clkdiv), .cfg_charge_sel_o(charge));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, int'(reg_rdata), int'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 8'h00, 8'h08);
    rd_chk("R1 status", 8'h03, 8'h00);
    rd_chk("R1 nv 0x28", 8'h28, 8'h00);
    chk("R1 cfg", int'({charge, clkdiv, therm_en, scan_slow}), 0);
  endtask

  task automatic t_refresh;
    idle(PER + 2);
    rd_chk("R2 0x28", 8'h28, 8'hA1);
    rd_chk("R2 0x29", 8'h29, 8'hB2);
    rd_chk("R2 0x30", 8'h30, 8'hA6);
    rd_chk("R2 0x31", 8'h31, 8'h11);
    rd_chk("R2 0x32", 8'h32, 8'h22);
    rd_chk("R2 0x33", 8'h33, 8'h33);
    chk("R10 scan", int'(scan_slow), 0);
    chk("R10 therm", int'(therm_en), 1);
    chk("R10 clkdiv", int'(clkdiv), 1);
    chk("R10 charge", int'(charge), 10);
  endtask

  task automatic t_ignored_enabled;
    wr(8'h29, 8'h55);
    chk("R5 busy", int'(busy_o), 0);
    idle(PER + 3);
    rd_chk("R5 cell kept", 8'h29, 8'hB2);
  endtask

  task automatic t_program;
    int cnt;
    wr(8'h00, 8'h00);
    wr(8'h28, 8'h5A);
    chk("R4 busy rise", int'(busy_o), 1);
    rd_chk("R3 read in busy", 8'h28, 8'hA1);
    rd_chk("R4 status busy", 8'h03, 8'h80);
    cnt = 0;
    while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R4 busy length", cnt, PROG);
    rd_chk("R3 after commit", 8'h28, 8'hA1);
    wr(8'h31, 8'h44);
    wr(8'h29, 8'h77);
    wr(8'h00, 8'h08);
    idle(PER + 4);
    chk("R9 still busy", int'(busy_o), 1);
    rd_chk("R9 no refresh in busy", 8'h28, 8'hA1);
    cnt = 0;
    while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
    idle(PER + 3);
    rd_chk("R4 commit 0x28", 8'h28, 8'h5A);
    rd_chk("R4 commit 0x31", 8'h31, 8'h44);
    rd_chk("R8 dropped 0x29", 8'h29, 8'hB2);
  endtask

  task automatic t_lowvolt;
    wr(8'h00, 8'h00);
    @(negedge clk); low1 = 1'b1;
    @(negedge clk); low1 = 1'b0;
    rd_chk("R6 flag1 sticky", 8'h03, 8'h04);
    wr(8'h32, 8'h99);
    chk("R7 refused flag", int'(busy_o), 0);
    wr(8'h03, 8'hFF);
    rd_chk("R6 write one keeps", 8'h03, 8'h04);
    wr(8'h03, 8'h00);
    rd_chk("R6 clear", 8'h03, 8'h00);
    @(negedge clk);
    low2 = 1'b1; reg_addr = 8'h03; reg_wdata = 8'h00; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; low2 = 1'b0;
    rd_chk("R6 set wins", 8'h03, 8'h08);
    wr(8'h03, 8'h00);
    rd_chk("R6 clear flag2", 8'h03, 8'h00);
    @(negedge clk);
    low1 = 1'b1; reg_addr = 8'h33; reg_wdata = 8'h5C; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; low1 = 1'b0;
    chk("R7 refused input", int'(busy_o), 0);
    wr(8'h03, 8'h00);
    wr(8'h00, 8'h08);
    idle(PER + 3);
    rd_chk("R7 cell 0x32 kept", 8'h32, 8'h22);
    rd_chk("R7 cell 0x33 kept", 8'h33, 8'h33);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refresh();
    t_ignored_enabled();
    t_program();
    t_lowvolt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    $display("FAIL watchdog actual 0x0 expected 0x1");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule